// File: doc/BRIEF.md
# T1 Multiframe Reframe Controller

This block supervises multiframe alignment for a T1 receive framer. It works beside the terminal-frame search logic and the CRC-6 calculator and consumes only their results. The inputs it takes are a strobed stream of received Fs framing bits, a list of extended-superframe candidate positions (a valid flag and a count), a superframe boundary strobe and the CRC-6 match result for that superframe. The outputs it drives are the alignment state, a reframe flag, a hold command for the signaling bits and a hold command for the framing and CRC error counters.

In the two Fs-pattern modes, the block hunts for the Fs bit history that marks the multiframe. That history is 00111 for the twelve-frame superframe and 000111000111 for the 72-frame subscriber-carrier format. In the extended-superframe mode, the block can commit to candidate 0 at once. It can also try each candidate in turn, giving each one a bounded number of CRC-6 checks. When every candidate has failed, it asks the terminal search to start again.

The search runs off-line. The committed candidate position (`active_pos`) keeps its old value during a reframe, so the rest of the receiver stays on the last alignment until a new one is committed.

The state machine has four states:
- S_HUNT_FS: Fs history hunt.
- S_ESF_WAIT: waiting for candidates.
- S_ESF_CONFIRM: trying CRC-6 on the current candidate.
- S_ALIGNED: aligned.

Its transitions are:
- T_FS_MATCH: HUNT to ALIGNED when the Fs history matches.
- T_TO_ESF: HUNT to WAIT when an ESF mode is selected.
- T_TO_FS: WAIT to HUNT when an Fs mode is selected.
- T_CAND_DIRECT: WAIT to ALIGNED when confirmation is off.
- T_CAND_TRY: WAIT to CONFIRM when confirmation is on.
- T_CRC_PASS: CONFIRM to ALIGNED.
- T_NEXT_CAND: CONFIRM stays in CONFIRM with the next index.
- T_RESTART: CONFIRM to WAIT when all candidates are used up.
- T_FORCE: any state to HUNT or WAIT, depending on the mode.

Top module: `t1_mf_reframe`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, the outputs are as follows: `mf_aligned`=0, `reframe_active`=1, `sig_freeze`=1, `err_suspend`=1, `active_pos`=0 and `restart_search`=0. The reset is synchronous and active high.
- R2: With `mode`=2'b00 (D4), `fs_bit` is taken only in cycles where `fs_strobe`=1. `mf_aligned` rises in the cycle after the strobe that completes the history 0,0,1,1,1 (oldest bit first), counting only bits received since the hunt began.
- R3: With `mode`=2'b01 (SLC), alignment requires the 12-bit history 0,0,0,1,1,1,0,0,0,1,1,1 (oldest bit first), counting only bits received since the hunt began. The five-bit D4 history alone does not align.
- R4: A `force_reframe` pulse in any state clears `mf_aligned` in the next cycle. It discards any partial Fs history and any candidate progress.
- R5: `reframe_active`, `sig_freeze` and `err_suspend` are all equal to the inverse of `mf_aligned` in every cycle.
- R6: With `mode`=2'b1x (ESF) and `crc_confirm_en`=0, `cand_valid`=1 with a non-zero `cand_count` aligns in the next cycle and sets `active_pos` to 0.
- R7: With ESF and `crc_confirm_en`=1, a candidate is committed only in a cycle where `sf_strobe`=1 and `crc_match`=1. `crc_match` without `sf_strobe` has no effect.
- R8: After 16 failed superframes (`sf_strobe`=1, `crc_match`=0) on one candidate, `cand_sel` moves on to the next index and the try count starts again.
- R9: When the sixteenth failure hits the last candidate (`cand_sel`+1 >= `cand_count`), `restart_search` is 1 during that failing cycle. The block then returns to waiting for candidates, with `cand_sel`=0.
- R10: `active_pos` holds its value during a reframe and changes only in the cycle in which `mf_aligned` rises. At that point it takes the index of the committed candidate.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode | input | 2 | 00 D4, 01 SLC, 1x ESF |
| crc_confirm_en | input | 1 | Require CRC-6 confirmation in ESF |
| fs_strobe | input | 1 | A new Fs bit is present on `fs_bit` |
| fs_bit | input | 1 | Received Fs framing bit |
| force_reframe | input | 1 | Start a new multiframe search |
| cand_valid | input | 1 | Terminal search has candidate positions |
| cand_count | input | CAND_W | Number of matching candidate positions |
| sf_strobe | input | 1 | Superframe boundary; `crc_match` is valid |
| crc_match | input | 1 | CRC-6 of the last superframe matched |
| mf_aligned | output | 1 | Multiframe alignment held |
| reframe_active | output | 1 | A reframe is in progress |
| sig_freeze | output | 1 | Hold signaling bits |
| err_suspend | output | 1 | Suspend Ft/Fs/ESF/CRC-6 error counting |
| cand_sel | output | CAND_W | Candidate index under CRC-6 trial |
| active_pos | output | CAND_W | Committed candidate index used by the receiver |
| restart_search | output | 1 | Pulse: restart the terminal framing search |

## Verification
The bench puts zero bits in front of a short run of ones. A design that compares against a zero-filled history register without counting the bits received would align on 1,1,1 alone. The bench also forces a reframe partway through a history; a design that kept the old bits would align too early. It feeds the D4 history while in SLC mode, which catches a pattern selector that is wired the wrong way. On the CRC-6 side, the bench looks at the fifteenth and the sixteenth failures to catch an off-by-one try limit. It watches `restart_search` on the last candidate. It also checks that `active_pos` keeps the old index during a trial, which a design that updated it on candidate entry would break.

// File: rtl/t1mf_pkg.sv
package t1mf_pkg;

    typedef enum logic [1:0] {
        S_HUNT_FS     = 2'd0,
        S_ESF_WAIT    = 2'd1,
        S_ESF_CONFIRM = 2'd2,
        S_ALIGNED     = 2'd3
    } mf_state_t;

    localparam int         D4_LEN  = 5;
    localparam logic [4:0] D4_PAT  = 5'b00111;
    localparam int         SLC_LEN = 12;
    localparam logic [11:0] SLC_PAT = 12'b000111000111;

    // mode[1] set selects the extended superframe flow
    function automatic logic is_esf(input logic [1:0] m);
        return m[1];
    endfunction

endpackage

// File: rtl/t1mf_fs_hist.sv
module t1mf_fs_hist
    import t1mf_pkg::*;
#(
    parameter int HIST_W = SLC_LEN
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic shift,
    input  logic bit_in,
    input  logic slc_sel,
    output logic match_now
);
    localparam int CNT_W = $clog2(HIST_W + 1);

    logic [HIST_W-1:0] hist, hist_nxt;
    logic [CNT_W-1:0]  seen, seen_nxt;
    logic              d4_hit, slc_hit;

    always_comb begin
        hist_nxt = {hist[HIST_W-2:0], bit_in};
        seen_nxt = (seen == CNT_W'(HIST_W)) ? seen : seen + 1'b1;
    end

    // pattern compare uses the history including the bit arriving now
    always_comb begin
        d4_hit  = (seen_nxt >= CNT_W'(D4_LEN))  && (hist_nxt[D4_LEN-1:0]  == D4_PAT);
        slc_hit = (seen_nxt >= CNT_W'(SLC_LEN)) && (hist_nxt[SLC_LEN-1:0] == SLC_PAT);
        match_now = shift && (slc_sel ? slc_hit : d4_hit);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            hist <= '0;
            seen <= '0;
        end else if (shift) begin
            hist <= hist_nxt;
            seen <= seen_nxt;
        end
    end

endmodule

// File: rtl/t1mf_try_track.sv
module t1mf_try_track #(
    parameter int CAND_W = 4,
    parameter int TRIES  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clear,
    input  logic              fail,
    input  logic [CAND_W-1:0] cand_count,
    output logic [CAND_W-1:0] cand_idx,
    output logic              exhausted
);
    localparam int TRY_W = (TRIES > 1) ? $clog2(TRIES) : 1;

    logic [TRY_W-1:0] tries;
    logic             last_try, last_cand;

    always_comb begin
        last_try  = (tries == TRY_W'(TRIES - 1));
        last_cand = ({1'b0, cand_idx} + 1'b1) >= {1'b0, cand_count};
        exhausted = fail && last_try && last_cand;
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            tries    <= '0;
            cand_idx <= '0;
        end else if (fail) begin
            if (!last_try) begin
                tries <= tries + 1'b1;
            end else begin
                tries    <= '0;
                cand_idx <= last_cand ? '0 : cand_idx + 1'b1;
            end
        end
    end

endmodule

// File: rtl/t1_mf_reframe.sv
module t1_mf_reframe
    import t1mf_pkg::*;
#(
    parameter int CAND_W    = 4,
    parameter int CRC_TRIES = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        mode,
    input  logic              crc_confirm_en,
    input  logic              fs_strobe,
    input  logic              fs_bit,
    input  logic              force_reframe,
    input  logic              cand_valid,
    input  logic [CAND_W-1:0] cand_count,
    input  logic              sf_strobe,
    input  logic              crc_match,
    output logic              mf_aligned,
    output logic              reframe_active,
    output logic              sig_freeze,
    output logic              err_suspend,
    output logic [CAND_W-1:0] cand_sel,
    output logic [CAND_W-1:0] active_pos,
    output logic              restart_search
);
    mf_state_t state, state_nxt;

    logic hist_clear, hist_shift, fs_match;
    logic trk_clear, trk_fail, trk_exhausted;
    logic cand_ok, commit;
    logic [CAND_W-1:0] commit_idx;

    t1mf_fs_hist #(.HIST_W(SLC_LEN)) u_hist (
        .clk       (clk),
        .rst       (rst),
        .clear     (hist_clear),
        .shift     (hist_shift),
        .bit_in    (fs_bit),
        .slc_sel   (mode[0]),
        .match_now (fs_match)
    );

    t1mf_try_track #(.CAND_W(CAND_W), .TRIES(CRC_TRIES)) u_track (
        .clk        (clk),
        .rst        (rst),
        .clear      (trk_clear),
        .fail       (trk_fail),
        .cand_count (cand_count),
        .cand_idx   (cand_sel),
        .exhausted  (trk_exhausted)
    );

    assign cand_ok = cand_valid && (cand_count != '0);

    // next state
    always_comb begin
        state_nxt = state;
        if (force_reframe) begin
            state_nxt = is_esf(mode) ? S_ESF_WAIT : S_HUNT_FS;            // T_FORCE
        end else begin
            unique case (state)
                S_HUNT_FS: begin
                    if (is_esf(mode))  state_nxt = S_ESF_WAIT;            // T_TO_ESF
                    else if (fs_match) state_nxt = S_ALIGNED;             // T_FS_MATCH
                end
                S_ESF_WAIT: begin
                    if (!is_esf(mode))       state_nxt = S_HUNT_FS;       // T_TO_FS
                    else if (cand_ok)
                        state_nxt = crc_confirm_en ? S_ESF_CONFIRM        // T_CAND_TRY
                                                   : S_ALIGNED;           // T_CAND_DIRECT
                end
                S_ESF_CONFIRM: begin
                    if (sf_strobe && crc_match) state_nxt = S_ALIGNED;    // T_CRC_PASS
                    else if (trk_exhausted)     state_nxt = S_ESF_WAIT;   // T_RESTART
                    // otherwise T_NEXT_CAND or another try in place
                end
                S_ALIGNED: state_nxt = S_ALIGNED;
                default:   state_nxt = S_HUNT_FS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) state <= S_HUNT_FS;
        else     state <= state_nxt;
    end

    // sub-block controls and commit decode
    always_comb begin
        hist_clear = force_reframe || (state != S_HUNT_FS);
        hist_shift = fs_strobe && (state == S_HUNT_FS) && !force_reframe && !is_esf(mode);
        trk_clear  = force_reframe || (state == S_ALIGNED) || (state == S_HUNT_FS);
        trk_fail   = (state == S_ESF_CONFIRM) && sf_strobe && !crc_match && !force_reframe;
        commit     = 1'b0;
        commit_idx = '0;
        if (!force_reframe) begin
            if (state == S_ESF_WAIT && is_esf(mode) && cand_ok && !crc_confirm_en) begin
                commit     = 1'b1;
                commit_idx = '0;
            end else if (state == S_ESF_CONFIRM && sf_strobe && crc_match) begin
                commit     = 1'b1;
                commit_idx = cand_sel;
            end
        end
    end

    // committed position: held through any reframe
    always_ff @(posedge clk) begin
        if (rst)         active_pos <= '0;
        else if (commit) active_pos <= commit_idx;
    end

    // outputs
    always_comb begin
        mf_aligned     = 1'b0;
        restart_search = 1'b0;
        unique case (state)
            S_ALIGNED:     mf_aligned     = 1'b1;
            S_ESF_CONFIRM: restart_search = trk_exhausted;
            S_HUNT_FS, S_ESF_WAIT: mf_aligned = 1'b0;
            default:       mf_aligned     = 1'b0;
        endcase
        reframe_active = !mf_aligned;
        sig_freeze     = !mf_aligned;
        err_suspend    = !mf_aligned;
    end

endmodule

// File: rtl/t1_mf_reframe_chk.sv
module t1_mf_reframe_chk #(
    parameter int CAND_W = 4
) (
    input logic              clk,
    input logic              rst,
    input logic [1:0]        mode,
    input logic              crc_confirm_en,
    input logic              fs_strobe,
    input logic              force_reframe,
    input logic              sf_strobe,
    input logic              crc_match,
    input logic              mf_aligned,
    input logic              reframe_active,
    input logic              sig_freeze,
    input logic              err_suspend,
    input logic [CAND_W-1:0] active_pos,
    input logic              restart_search
);
    AST_RESET_UNALIGNED: assert property (@(posedge clk) rst |=> !mf_aligned && !restart_search); // R1

    AST_FS_NEEDS_STROBE: assert property (@(posedge clk) disable iff (rst)
        ($rose(mf_aligned) && !mode[1]) |-> $past(fs_strobe)); // R2

    AST_FORCE_DROPS: assert property (@(posedge clk) disable iff (rst)
        force_reframe |=> !mf_aligned); // R4

    AST_HOLDS_TRACK: assert property (@(posedge clk) disable iff (rst)
        (sig_freeze == reframe_active) && (err_suspend == reframe_active)); // R5

    AST_CRC_COMMIT: assert property (@(posedge clk) disable iff (rst)
        ($rose(mf_aligned) && mode[1] && crc_confirm_en && $stable(crc_confirm_en))
        |-> $past(sf_strobe && crc_match)); // R7

    AST_RESTART_ON_FAIL: assert property (@(posedge clk) disable iff (rst)
        restart_search |-> (sf_strobe && !crc_match && !mf_aligned)); // R9

    AST_POS_HELD: assert property (@(posedge clk) disable iff (rst)
        !mf_aligned |=> (mf_aligned || $stable(active_pos))); // R10

endmodule

bind t1_mf_reframe t1_mf_reframe_chk #(.CAND_W(CAND_W)) u_chk (
    .clk            (clk),
    .rst            (rst),
    .mode           (mode),
    .crc_confirm_en (crc_confirm_en),
    .fs_strobe      (fs_strobe),
    .force_reframe  (force_reframe),
    .sf_strobe      (sf_strobe),
    .crc_match      (crc_match),
    .mf_aligned     (mf_aligned),
    .reframe_active (reframe_active),
    .sig_freeze     (sig_freeze),
    .err_suspend    (err_suspend),
    .active_pos     (active_pos),
    .restart_search (restart_search)
);

// File: tb/sim_t1_mf_reframe.sv
module sim_t1_mf_reframe;
    localparam int CW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] mode = 2'b00;
    logic crc_confirm_en = 1'b0;
    logic fs_strobe = 1'b0, fs_bit = 1'b0, force_reframe = 1'b0;
    logic cand_valid = 1'b0;
    logic [CW-1:0] cand_count = '0;
    logic sf_strobe = 1'b0, crc_match = 1'b0;
    logic mf_aligned, reframe_active, sig_freeze, err_suspend, restart_search;
    logic [CW-1:0] cand_sel, active_pos;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    typedef struct {
        bit          al;
        logic [CW-1:0] pos;
        logic [CW-1:0] sel;
        bit          chk_sel;
        bit          rs;
        string       tag;
    } exp_t;
    exp_t q[$];

    always #5 clk = ~clk;

    t1_mf_reframe #(.CAND_W(CW), .CRC_TRIES(16)) u0 (
        .clk(clk), .rst(rst), .mode(mode), .crc_confirm_en(crc_confirm_en),
        .fs_strobe(fs_strobe), .fs_bit(fs_bit), .force_reframe(force_reframe),
        .cand_valid(cand_valid), .cand_count(cand_count), .sf_strobe(sf_strobe),
        .crc_match(crc_match), .mf_aligned(mf_aligned), .reframe_active(reframe_active),
        .sig_freeze(sig_freeze), .err_suspend(err_suspend), .cand_sel(cand_sel),
        .active_pos(active_pos), .restart_search(restart_search)
    );

    task automatic drv(input logic fs, input logic b, input logic frc,
                       input logic sf, input logic crc);
        fs_strobe = fs; fs_bit = b; force_reframe = frc; sf_strobe = sf; crc_match = crc;
    endtask

    task automatic expect_out(input bit al, input logic [CW-1:0] pos, input bit chk_sel,
                              input logic [CW-1:0] sel, input bit rs, input string tag);
        exp_t e;
        e.al = al; e.pos = pos; e.sel = sel; e.chk_sel = chk_sel; e.rs = rs; e.tag = tag;
        q.push_back(e);
    endtask

    task automatic go();
        @(negedge clk);
    endtask

    // Fs bits fed oldest first; no alignment may appear before the last edge
    task automatic feed(input logic [15:0] v, input int n, input logic [CW-1:0] pos,
                        input string tag);
        for (int i = n - 1; i >= 0; i--) begin
            drv(1'b1, v[i], 1'b0, 1'b0, 1'b0);
            expect_out(1'b0, pos, 1'b0, '0, 1'b0, tag);
            go();
        end
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    // monitor: compares queued expectations just before the next rising edge
    initial begin
        forever begin
            @(negedge clk);
            #4;
            while (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (mf_aligned !== e.al || reframe_active !== !e.al || sig_freeze !== !e.al ||
                    err_suspend !== !e.al || active_pos !== e.pos || restart_search !== e.rs ||
                    (e.chk_sel && cand_sel !== e.sel)) begin
                    failures++;
                    $display("FAIL %s (R5 flags): got al=%0b rf=%0b frz=%0b sus=%0b pos=%0d sel=%0d rs=%0b exp al=%0b pos=%0d sel=%0d rs=%0b",
                             e.tag, mf_aligned, reframe_active, sig_freeze, err_suspend,
                             active_pos, cand_sel, restart_search, e.al, e.pos, e.sel, e.rs);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        go(); go();
        expect_out(1'b0, '0, 1'b1, '0, 1'b0, "R1 during reset");
        go();
        rst = 1'b0;
        expect_out(1'b0, '0, 1'b1, '0, 1'b0, "R1 after reset");
        go();

        // D4 hunt: 1,0,0,1,1,1
        feed(16'b100111, 6, '0, "R2 d4 partial");
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R2 d4 aligned");
        go();
        // strobe-less bits ignored while aligned; force
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R4 before force edge");
        go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out(1'b0, '0, 1'b0, '0, 1'b0, "R4 force drops alignment");
        go();
        // only three ones after restart must not align on zero-filled history
        feed(16'b111, 3, '0, "R2 short history");
        expect_out(1'b0, '0, 1'b0, '0, 1'b0, "R2 three bits not enough");
        go();
        feed(16'b00111, 5, '0, "R2 d4 second");
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R2 d4 realigned");
        go();

        // force mid-hunt discards partial history
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); go();
        feed(16'b001, 3, '0, "R4 partial");
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0);
        expect_out(1'b0, '0, 1'b0, '0, 1'b0, "R4 force in hunt");
        go();
        feed(16'b11, 2, '0, "R4 tail after force");
        expect_out(1'b0, '0, 1'b0, '0, 1'b0, "R4 history cleared by force");
        go();
        feed(16'b00111, 5, '0, "R2 after mid-hunt force");
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R2 aligned after clean history");
        go();

        // SLC mode
        mode = 2'b01;
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        feed(16'b00111, 5, '0, "R3 d4 history in slc");
        expect_out(1'b0, '0, 1'b0, '0, 1'b0, "R3 d4 history does not align slc");
        go();
        feed(16'b000111000111, 12, '0, "R3 slc partial");
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R3 slc aligned");
        go();

        // ESF without confirmation
        mode = 2'b10;
        crc_confirm_en = 1'b0;
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cand_valid = 1'b1; cand_count = 4'd3;
        expect_out(1'b0, '0, 1'b1, '0, 1'b0, "R6 waiting");
        go();
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R6 direct commit");
        go();
        cand_valid = 1'b0;

        // ESF with confirmation, two candidates
        crc_confirm_en = 1'b1;
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cand_valid = 1'b1; cand_count = 4'd2;
        go();
        cand_valid = 1'b0;
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
        expect_out(1'b0, '0, 1'b1, '0, 1'b0, "R7 crc without strobe");
        go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out(1'b0, '0, 1'b1, '0, 1'b0, "R7 crc without strobe ignored");
        go();
        for (int i = 0; i < 16; i++) begin
            drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            if (i == 15) expect_out(1'b0, '0, 1'b1, '0, 1'b0, "R8 sixteenth fail on first cand");
            go();
        end
        for (int i = 0; i < 3; i++) begin
            drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            expect_out(1'b0, '0, 1'b1, 4'd1, 1'b0, "R8 moved to second cand");
            go();
        end
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(1'b0, '0, 1'b1, 4'd1, 1'b0, "R10 old position held in trial");
        go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out(1'b1, 4'd1, 1'b0, '0, 1'b0, "R7 R10 committed second cand");
        go();

        // exhaustion with one candidate
        drv(1'b0, 1'b0, 1'b1, 1'b0, 1'b0); go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cand_valid = 1'b1; cand_count = 4'd1;
        go();
        cand_valid = 1'b0;
        for (int i = 0; i < 16; i++) begin
            drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
            if (i == 14) expect_out(1'b0, 4'd1, 1'b1, '0, 1'b0, "R9 fifteenth fail no restart");
            if (i == 15) expect_out(1'b0, 4'd1, 1'b1, '0, 1'b1, "R9 restart on sixteenth fail");
            go();
        end
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out(1'b0, 4'd1, 1'b1, '0, 1'b0, "R9 back to waiting");
        go();
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        expect_out(1'b0, 4'd1, 1'b1, '0, 1'b0, "R9 no candidates yet crc ignored");
        go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        cand_valid = 1'b1; cand_count = 4'd1;
        expect_out(1'b0, 4'd1, 1'b0, '0, 1'b0, "R9 still waiting");
        go();
        cand_valid = 1'b0;
        drv(1'b0, 1'b0, 1'b0, 1'b1, 1'b1);
        go();
        drv(1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        expect_out(1'b1, '0, 1'b0, '0, 1'b0, "R7 R10 recommitted index 0");
        go();
        go();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule